// File: doc/BRIEF.md
# Bit-Oriented Message Majority Filter

This block debounces decoded bit-oriented message codes before they reach a receive byte queue. An upstream deframer presents one pattern per strobe. Each pattern is one of three kinds: a 6-bit message code marked valid, the idle pattern, or a pattern that is neither. The block keeps a sliding record of the last ten patterns. It reports a code only when that code holds a clear majority of the record.

When a code wins the vote, the block enters a locked state. It then writes two bytes to the queue on consecutive cycles: the code, followed by a fixed status byte that marks the entry as filtered. While locked, the block stays silent. It leaves the locked state when the line has clearly moved away from the accepted code, meaning either a run of different valid codes or repeated idle patterns. On leaving, it forgets its history, so any code must win a complete new vote before it is reported again.

Top module: `bom_majority_filter`

## Requirements
- R1: While unlocked, a strobe carrying a valid code C causes locking (`filt_locked` high from the cycle after the strobe) when C occupies at least 7 of the 10 most recent pattern slots, this strobe included.
- R2: On locking, `fifo_wr` is high for exactly two consecutive cycles. In the first cycle (the one after the strobe) `fifo_data` is the code zero-extended to 8 bits, with bits 7:6 equal to 0. In the second cycle `fifo_data` is the status byte 0x80.
- R3: While locked, the 4th consecutive valid strobe whose code differs from the accepted code unlocks the block. A matching code, an idle pattern or a neither-kind pattern restarts this run.
- R4: While locked, the 4th idle pattern since locking or since the last matching code unlocks the block.
- R5: Outside the two-cycle write after locking, `fifo_wr` stays low, including when the accepted code is received again.
- R6: A strobe carrying the accepted code clears both the mismatch run and the idle count.
- R7: Unlocking empties the history, including the pattern that caused it, so the next lock needs 7 strobes of one code after the exit.
- R8: Idle and neither-kind patterns occupy a history slot but give no vote. A pattern flagged both valid and idle counts as idle.
- R9: Without a strobe, `filt_locked` keeps its value and no write occurs. After reset, `filt_locked` and `fifo_wr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_stb | input | 1 | One-cycle strobe marking a new pattern |
| pat_code | input | 6 | Message code of the pattern |
| pat_valid | input | 1 | Pattern carries a valid code |
| pat_idle | input | 1 | Pattern is the idle pattern |
| fifo_wr | output | 1 | Byte write enable toward the receive queue |
| fifo_data | output | 8 | Byte written: code, then status |
| filt_locked | output | 1 | A code is currently accepted |

## Verification
A corrupted history slot or a miscounted vote shows up as `filt_locked` rising one strobe too early or too late, and a byte pair that appears or goes missing in the cycle right after that strobe. A wrong mismatch count or idle count shifts the unlock by a strobe; this is visible on `filt_locked` one cycle after the deciding pattern. A history that is not cleared on exit lets a code relock in fewer than 7 fresh strobes. Each of these faults therefore appears at the ports within one or two cycles of the pattern that exposes it.

// File: rtl/bomf_pkg.sv
package bomf_pkg;

  // Kind of a received pattern after flag resolution.
  typedef enum logic [1:0] {
    PAT_NONE  = 2'd0,
    PAT_VALID = 2'd1,
    PAT_IDLE  = 2'd2
  } pat_kind_t;

  // The idle flag takes precedence over the valid flag.
  function automatic pat_kind_t classify(input logic valid, input logic idle);
    if (idle)       return PAT_IDLE;
    else if (valid) return PAT_VALID;
    else            return PAT_NONE;
  endfunction

endpackage

// File: rtl/bomf_history.sv
module bomf_history #(
  parameter int CODE_W = 6,
  parameter int DEPTH  = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic [CNT_W-1:0]  vote_cnt
);

  // slot 0 holds the newest pattern
  logic [DEPTH-1:0]  slot_v;
  logic [DEPTH-1:0]  slot_v_nxt;
  logic [CODE_W-1:0] slot_c     [DEPTH];
  logic [CODE_W-1:0] slot_c_nxt [DEPTH];
  logic [DEPTH-2:0]  hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g == 0) begin : g_head
      always_comb begin
        slot_v_nxt[g] = slot_v[g];
        slot_c_nxt[g] = slot_c[g];
        if (clear) begin
          slot_v_nxt[g] = 1'b0;
          slot_c_nxt[g] = '0;
        end else if (shift_en) begin
          slot_v_nxt[g] = in_valid;
          slot_c_nxt[g] = in_code;
        end
      end
    end else begin : g_body
      always_comb begin
        slot_v_nxt[g] = slot_v[g];
        slot_c_nxt[g] = slot_c[g];
        if (clear) begin
          slot_v_nxt[g] = 1'b0;
          slot_c_nxt[g] = '0;
        end else if (shift_en) begin
          slot_v_nxt[g] = slot_v[g-1];
          slot_c_nxt[g] = slot_c[g-1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v[g] <= 1'b0;
        slot_c[g] <= '0;
      end else if (shift_en || clear) begin
        slot_v[g] <= slot_v_nxt[g];
        slot_c[g] <= slot_c_nxt[g];
      end
    end
  end

  // The oldest slot drops out when the incoming pattern enters.
  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_cmp
    assign hit[g] = slot_v[g] && (slot_c[g] == in_code);
  end

  always_comb begin
    vote_cnt = '0;
    if (in_valid) begin
      vote_cnt = CNT_W'(1);
      for (int i = 0; i < DEPTH - 1; i++) begin
        vote_cnt = vote_cnt + CNT_W'(hit[i]);
      end
    end
  end

endmodule

// File: rtl/bomf_lock_ctl.sv
module bomf_lock_ctl
  import bomf_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int CNT_W      = 4,
  parameter int VOTES      = 7,
  parameter int MISS_LIMIT = 4,
  parameter int IDLE_LIMIT = 4,
  localparam int MW = $clog2(MISS_LIMIT + 1),
  localparam int IW = $clog2(IDLE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  pat_kind_t         kind,
  input  logic [CODE_W-1:0] code,
  input  logic [CNT_W-1:0]  vote_cnt,
  output logic              locked,
  output logic              accept,
  output logic              leave
);

  logic [CODE_W-1:0] acc_code, acc_code_nxt;
  logic [MW-1:0]     miss_cnt, miss_cnt_nxt;
  logic [IW-1:0]     idle_cnt, idle_cnt_nxt;
  logic              locked_nxt;
  logic              match;

  assign match = (kind == PAT_VALID) && (code == acc_code);

  always_comb begin
    locked_nxt   = locked;
    acc_code_nxt = acc_code;
    miss_cnt_nxt = miss_cnt;
    idle_cnt_nxt = idle_cnt;
    accept       = 1'b0;
    leave        = 1'b0;
    if (stb) begin
      if (!locked) begin
        if ((kind == PAT_VALID) && (vote_cnt >= CNT_W'(VOTES))) begin
          accept       = 1'b1;
          locked_nxt   = 1'b1;
          acc_code_nxt = code;
          miss_cnt_nxt = '0;
          idle_cnt_nxt = '0;
        end
      end else if (match) begin
        miss_cnt_nxt = '0;
        idle_cnt_nxt = '0;
      end else if (kind == PAT_VALID) begin
        if (miss_cnt == MW'(MISS_LIMIT - 1)) leave = 1'b1;
        else miss_cnt_nxt = miss_cnt + MW'(1);
      end else begin
        miss_cnt_nxt = '0;
        if (kind == PAT_IDLE) begin
          if (idle_cnt == IW'(IDLE_LIMIT - 1)) leave = 1'b1;
          else idle_cnt_nxt = idle_cnt + IW'(1);
        end
      end
      if (leave) begin
        locked_nxt   = 1'b0;
        miss_cnt_nxt = '0;
        idle_cnt_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      acc_code <= '0;
      miss_cnt <= '0;
      idle_cnt <= '0;
    end else if (stb) begin
      locked   <= locked_nxt;
      acc_code <= acc_code_nxt;
      miss_cnt <= miss_cnt_nxt;
      idle_cnt <= idle_cnt_nxt;
    end
  end

endmodule

// File: rtl/bomf_emit.sv
module bomf_emit #(
  parameter int          CODE_W      = 6,
  parameter logic [7:0]  STATUS_BYTE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CODE_W-1:0] code,
  output logic              wr,
  output logic [7:0]        data
);

  logic       pend, pend_nxt;
  logic       wr_nxt;
  logic [7:0] data_nxt;

  always_comb begin
    pend_nxt = 1'b0;
    wr_nxt   = 1'b0;
    data_nxt = data;
    if (accept) begin
      wr_nxt   = 1'b1;
      data_nxt = {{(8 - CODE_W){1'b0}}, code};
      pend_nxt = 1'b1;
    end else if (pend) begin
      wr_nxt   = 1'b1;
      data_nxt = STATUS_BYTE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      wr   <= 1'b0;
      data <= '0;
    end else begin
      pend <= pend_nxt;
      wr   <= wr_nxt;
      data <= data_nxt;
    end
  end

endmodule

// File: rtl/bom_majority_filter.sv
module bom_majority_filter
  import bomf_pkg::*;
#(
  parameter int         CODE_W      = 6,
  parameter int         DEPTH       = 10,
  parameter int         VOTES       = 7,
  parameter int         MISS_LIMIT  = 4,
  parameter int         IDLE_LIMIT  = 4,
  parameter logic [7:0] STATUS_BYTE = 8'h80,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pat_stb,
  input  logic [CODE_W-1:0] pat_code,
  input  logic              pat_valid,
  input  logic              pat_idle,
  output logic              fifo_wr,
  output logic [7:0]        fifo_data,
  output logic              filt_locked
);

  pat_kind_t        kind;
  logic [CNT_W-1:0] vote_cnt;
  logic             accept;
  logic             leave;

  assign kind = classify(pat_valid, pat_idle);

  bomf_history #(
    .CODE_W (CODE_W),
    .DEPTH  (DEPTH)
  ) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (pat_stb),
    .clear    (leave),
    .in_valid (kind == PAT_VALID),
    .in_code  (pat_code),
    .vote_cnt (vote_cnt)
  );

  bomf_lock_ctl #(
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W),
    .VOTES      (VOTES),
    .MISS_LIMIT (MISS_LIMIT),
    .IDLE_LIMIT (IDLE_LIMIT)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (pat_stb),
    .kind     (kind),
    .code     (pat_code),
    .vote_cnt (vote_cnt),
    .locked   (filt_locked),
    .accept   (accept),
    .leave    (leave)
  );

  bomf_emit #(
    .CODE_W      (CODE_W),
    .STATUS_BYTE (STATUS_BYTE)
  ) u_emit (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .code   (pat_code),
    .wr     (fifo_wr),
    .data   (fifo_data)
  );

endmodule

// File: rtl/bomf_checker.sv
module bomf_checker #(
  parameter int         CODE_W      = 6,
  parameter logic [7:0] STATUS_BYTE = 8'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pat_stb,
  input logic [CODE_W-1:0] pat_code,
  input logic              pat_valid,
  input logic              pat_idle,
  input logic              fifo_wr,
  input logic [7:0]        fifo_data,
  input logic              filt_locked
);

  p_lock_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_locked) |-> $past(pat_stb && pat_valid && !pat_idle));

  p_code_byte_on_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_locked) |-> (fifo_wr && fifo_data == {{(8 - CODE_W){1'b0}}, $past(pat_code)}));

  p_status_follows_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_data != STATUS_BYTE) |=> (fifo_wr && fifo_data == STATUS_BYTE));

  p_status_needs_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_data == STATUS_BYTE) |-> $past(fifo_wr && fifo_data != STATUS_BYTE));

  p_no_write_unless_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_data != STATUS_BYTE) |-> $rose(filt_locked));

  p_unlock_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_locked) |-> $past(pat_stb));

  p_quiet_without_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_stb |=> $stable(filt_locked));

endmodule

bind bom_majority_filter bomf_checker #(
  .CODE_W      (CODE_W),
  .STATUS_BYTE (STATUS_BYTE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pat_stb     (pat_stb),
  .pat_code    (pat_code),
  .pat_valid   (pat_valid),
  .pat_idle    (pat_idle),
  .fifo_wr     (fifo_wr),
  .fifo_data   (fifo_data),
  .filt_locked (filt_locked)
);

// File: tb/bom_majority_filter_test.sv
`timescale 1ns/1ps
module bom_majority_filter_test;

  localparam logic [7:0] STATUS = 8'h80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pat_stb = 1'b0;
  logic [5:0] pat_code = '0;
  logic       pat_valid = 1'b0;
  logic       pat_idle = 1'b0;
  logic       fifo_wr;
  logic [7:0] fifo_data;
  logic       filt_locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit       m_v [10];
  bit [5:0] m_c [10];
  bit       m_locked = 1'b0;
  bit [5:0] m_acc = '0;
  int       m_miss = 0;
  int       m_idle = 0;

  always #10 clk = ~clk;

  bom_majority_filter uut (
    .clk(clk), .rst_n(rst_n), .pat_stb(pat_stb), .pat_code(pat_code),
    .pat_valid(pat_valid), .pat_idle(pat_idle), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .filt_locked(filt_locked)
  );

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance the model by one pattern; returns 1 on acceptance, sets reason tag.
  function automatic bit model_step(bit v, bit i, bit [5:0] c, output string tag);
    bit is_idle = i;
    bit is_valid = v && !i;
    int votes = 0;
    bit acc = 1'b0;
    bit ext = 1'b0;
    tag = "R9";
    if (is_valid) begin
      votes = 1;
      for (int k = 0; k < 9; k++) if (m_v[k] && m_c[k] == c) votes++;
    end
    if (!m_locked) begin
      if (is_valid && votes >= 7) begin
        acc = 1'b1; m_locked = 1'b1; m_acc = c; m_miss = 0; m_idle = 0; tag = "R1";
      end
    end else if (is_valid && c == m_acc) begin
      m_miss = 0; m_idle = 0; tag = "R6";
    end else if (is_valid) begin
      m_miss++;
      if (m_miss == 4) begin ext = 1'b1; tag = "R3"; end
    end else begin
      m_miss = 0;
      if (is_idle) begin
        m_idle++;
        if (m_idle == 4) begin ext = 1'b1; tag = "R4"; end
      end else tag = "R8";
    end
    for (int k = 9; k > 0; k--) begin m_v[k] = m_v[k-1]; m_c[k] = m_c[k-1]; end
    m_v[0] = is_valid; m_c[0] = c;
    if (ext) begin
      for (int k = 0; k < 10; k++) begin m_v[k] = 1'b0; m_c[k] = '0; end
      m_locked = 1'b0; m_miss = 0; m_idle = 0;
    end
    return acc;
  endfunction

  task automatic send(bit v, bit i, bit [5:0] c, int gap);
    string tag;
    bit acc;
    @(negedge clk);
    pat_stb = 1'b1; pat_valid = v; pat_idle = i; pat_code = c;
    acc = model_step(v, i, c, tag);
    @(negedge clk);
    pat_stb = 1'b0;
    check_val(tag, filt_locked, m_locked);
    if (acc) begin
      check_val("R2 code write", fifo_wr, 1);
      check_val("R2 code byte", fifo_data, {2'b00, c});
    end else begin
      check_val("R5 no write", fifo_wr, 0);
    end
    @(negedge clk);
    if (acc) begin
      check_val("R2 status write", fifo_wr, 1);
      check_val("R2 status byte", fifo_data, STATUS);
    end else begin
      check_val("R5 no write", fifo_wr, 0);
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check_val("R9 idle wr", fifo_wr, 0);
      check_val("R9 idle lock", filt_locked, m_locked);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    bit [5:0] main_code;
    r = $urandom(32'd20240611);
    for (int k = 0; k < 10; k++) begin m_v[k] = 1'b0; m_c[k] = '0; end
    repeat (3) @(negedge clk);
    check_val("R9 reset wr", fifo_wr, 0);
    check_val("R9 reset lock", filt_locked, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: six votes are not enough, the seventh locks
    for (int k = 0; k < 6; k++) send(1, 0, 6'h15, 0);
    check_val("R1 six votes", filt_locked, 0);
    send(1, 0, 6'h15, 1);
    check_val("R1 seven votes", filt_locked, 1);
    // R5: repeats write nothing
    for (int k = 0; k < 3; k++) send(1, 0, 6'h15, 0);
    // R6 / R3: match and non-valid patterns restart the mismatch run
    for (int k = 0; k < 3; k++) send(1, 0, 6'h0A, 0);
    send(1, 0, 6'h15, 0);
    for (int k = 0; k < 3; k++) send(1, 0, 6'h0A, 0);
    check_val("R6 run restarted", filt_locked, 1);
    send(0, 1, 6'h00, 0);
    for (int k = 0; k < 3; k++) send(1, 0, 6'h0A, 0);
    check_val("R3 idle breaks run", filt_locked, 1);
    send(1, 0, 6'h0A, 0);
    check_val("R3 fourth mismatch", filt_locked, 0);
    // R7: fresh window needed after exit
    for (int k = 0; k < 6; k++) send(1, 0, 6'h0A, 0);
    check_val("R7 history cleared", filt_locked, 0);
    send(1, 0, 6'h0A, 0);
    check_val("R7 relock", filt_locked, 1);
    // R4: idles counted since last match; both flags count as idle (R8)
    for (int k = 0; k < 3; k++) send(0, 1, 6'h00, 0);
    send(1, 0, 6'h0A, 0);
    for (int k = 0; k < 3; k++) send(0, 1, 6'h00, 0);
    check_val("R4 three idles", filt_locked, 1);
    send(1, 1, 6'h0A, 0);
    check_val("R4 R8 fourth idle", filt_locked, 0);
    // R8: non-vote patterns take slots
    send(1, 0, 6'h21, 0); send(1, 0, 6'h21, 0); send(0, 1, 6'h00, 0);
    send(1, 0, 6'h21, 0); send(1, 0, 6'h21, 0); send(0, 0, 6'h21, 0);
    send(1, 0, 6'h21, 0); send(1, 0, 6'h21, 0); send(0, 1, 6'h00, 0);
    check_val("R8 six in nine", filt_locked, 0);
    send(1, 0, 6'h21, 0);
    check_val("R8 seven in ten", filt_locked, 1);
    for (int k = 0; k < 4; k++) send(0, 1, 6'h00, 0);
    check_val("R4 exit", filt_locked, 0);

    // constrained random traffic
    main_code = 6'h2C;
    for (int n = 0; n < 800; n++) begin
      int unsigned sel = $urandom % 16;
      int unsigned gap = $urandom % 3;
      if (($urandom % 64) == 0) main_code = 6'($urandom);
      if (sel < 9)       send(1, 0, main_code, gap);
      else if (sel < 11) send(1, 0, main_code ^ 6'h01, gap);
      else if (sel < 12) send(1, 0, 6'($urandom), gap);
      else if (sel < 14) send(0, 1, 6'($urandom), gap);
      else if (sel < 15) send(1, 1, main_code, gap);
      else               send(0, 0, main_code, gap);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule